// File: doc/BRIEF.md
# Host I/O Command Dispatch Sequencer

This block sits between a host's start-I/O strobe and a serial interface. When the host asserts its strobe together with a two-bit bus command, the sequencer decides whether the command asks it to load control settings, begin receiving or begin transmitting. It then raises a two-bit task-wakeup code that asks host microcode to run the matching service routine. While no command is pending, the receive and transmit engines can request data service. The sequencer forwards those requests as wakeups, and a receive request wins over a transmit request.

A control or input-start wakeup stays raised until two things have happened: the host has dropped its strobe and it has acknowledged through the wakeup-clear input. A start-output command raises no wakeup. It only holds the sequencer busy until the strobe falls. Control and no wakeup share code 0, so a separate valid flag marks the cycles in which a code is being driven. State, code and flag all come from registers.

Top module: `hdq_dispatch`

## Requirements
- R1: While `rst_n` is low, `state` is 0, `wake_vld` is 0 and `wake_code` is 0. Assertion of `rst_n` takes effect at once. After release, the block stays in reset for `RST_STAGES` further clock edges.
- R2: `state` encodes idle=0, start-output=1, set-control=2, start-input=3. It shows the state entered at the most recent clock edge.
- R3: `wake_code` encodes control=0, input-start=1, input-data=2, output-data=3. `wake_code` reads 0 in every cycle where `wake_vld` is 0.
- R4: In idle, with `sio`=1 and `bus_cmd`=3, the next edge enters set-control with `wake_vld`=1 and code 0.
- R5: In idle, with `sio`=1 and `bus_cmd`=2, the next edge enters start-input with `wake_vld`=1 and code 1.
- R6: In idle, with `sio`=1 and `bus_cmd`=1, the next edge enters start-output with `wake_vld`=0.
- R7: In idle, with `sio`=1 and `bus_cmd`=0, the block stays idle with `wake_vld`=0. The data requests and `wake_clr` have no effect in that cycle.
- R8: In idle, with `sio`=0, `in_data_req` gives code 2 and `out_data_req` alone gives code 3. When both are high, the code is 2. The state stays idle. With neither request, `wake_vld` is 0.
- R9: Start-output raises no wakeup and stays put while `sio`=1. The edge after a cycle with `sio`=0 returns it to idle.
- R10: Set-control and start-input keep their own wakeup while `sio`=1, even if `wake_clr`=1. They keep it while `sio`=0 and `wake_clr`=0. They return to idle with no wakeup on the edge after a cycle with `sio`=0 and `wake_clr`=1.
- R11: Outside idle, `bus_cmd`, `in_data_req` and `out_data_req` have no effect on `state`, `wake_code` or `wake_vld`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sio | input | 1 | Host start-I/O strobe |
| bus_cmd | input | 2 | Command presented with the strobe |
| wake_clr | input | 1 | Host acknowledge that clears a pending control or input-start wakeup |
| in_data_req | input | 1 | Receive engine requests data service |
| out_data_req | input | 1 | Transmit engine requests data service |
| state | output | 2 | Registered sequencer state |
| wake_code | output | 2 | Registered wakeup code |
| wake_vld | output | 1 | A wakeup code is being driven |

## Verification
The bench builds the block with its default `RST_STAGES` of 2. This makes the two-edge reset release visible. It also lets a mid-run asynchronous reset, taken from set-control, be compared against a reference that ignores the synchronizer. With the default two-bit command and code widths, all four bus commands and all four wakeup codes can be reached. Each of them appears both in directed sequences and in a long random stretch where strobe, acknowledge and data requests toggle independently.

// File: rtl/hdq_pkg.sv
package hdq_pkg;
  localparam int STATE_W = 2;
  localparam int CODE_W  = 2;
  localparam int CMD_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE = 2'd0,
    ST_OUT  = 2'd1,
    ST_CTL  = 2'd2,
    ST_IN   = 2'd3
  } seq_state_e;

  typedef enum logic [CODE_W-1:0] {
    WK_CTL     = 2'd0,
    WK_INSTART = 2'd1,
    WK_INDATA  = 2'd2,
    WK_OUTDATA = 2'd3
  } wake_e;

  localparam logic [CMD_W-1:0] CMD_OTHER = 2'd0;
  localparam logic [CMD_W-1:0] CMD_OUT   = 2'd1;
  localparam logic [CMD_W-1:0] CMD_IN    = 2'd2;
  localparam logic [CMD_W-1:0] CMD_CTL   = 2'd3;

  typedef struct packed {
    logic ctl;
    logic in;
    logic out;
  } host_req_t;
endpackage

// File: rtl/hdq_rst_sync.sv
module hdq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/hdq_cmd_decode.sv
module hdq_cmd_decode
  import hdq_pkg::*;
(
  input  logic             sio,
  input  logic [CMD_W-1:0] bus_cmd,
  output host_req_t        req
);
  always_comb begin
    req = '0;
    if (sio) begin
      case (bus_cmd)
        CMD_CTL: req.ctl = 1'b1;
        CMD_IN:  req.in  = 1'b1;
        CMD_OUT: req.out = 1'b1;
        default: req     = '0;
      endcase
    end
  end
endmodule

// File: rtl/hdq_next.sv
module hdq_next
  import hdq_pkg::*;
(
  input  seq_state_e state_q,
  input  logic       sio,
  input  host_req_t  req,
  input  logic       wake_clr,
  input  logic       in_data_req,
  input  logic       out_data_req,
  output seq_state_e state_d,
  output wake_e      code_d,
  output logic       vld_d
);
  always_comb begin
    state_d = state_q;
    code_d  = WK_CTL;
    vld_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (sio) begin
          if (req.ctl) begin
            state_d = ST_CTL;
            code_d  = WK_CTL;
            vld_d   = 1'b1;
          end else if (req.in) begin
            state_d = ST_IN;
            code_d  = WK_INSTART;
            vld_d   = 1'b1;
          end else if (req.out) begin
            state_d = ST_OUT;
          end
        end else if (in_data_req) begin
          code_d = WK_INDATA;
          vld_d  = 1'b1;
        end else if (out_data_req) begin
          code_d = WK_OUTDATA;
          vld_d  = 1'b1;
        end
      end
      ST_OUT: begin
        if (!sio) state_d = ST_IDLE;
      end
      ST_CTL, ST_IN: begin
        if (!sio && wake_clr) begin
          state_d = ST_IDLE;
        end else begin
          code_d = (state_q == ST_CTL) ? WK_CTL : WK_INSTART;
          vld_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/hdq_dispatch.sv
module hdq_dispatch
  import hdq_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sio,
  input  logic [CMD_W-1:0]   bus_cmd,
  input  logic               wake_clr,
  input  logic               in_data_req,
  input  logic               out_data_req,
  output logic [STATE_W-1:0] state,
  output logic [CODE_W-1:0]  wake_code,
  output logic               wake_vld
);
  logic       rst_sync_n;
  host_req_t  req;
  seq_state_e state_q, state_d;
  wake_e      code_q, code_d;
  logic       wake_vld_q, vld_d;
  logic       code_en;

  hdq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hdq_cmd_decode u_decode (
    .sio     (sio),
    .bus_cmd (bus_cmd),
    .req     (req)
  );

  hdq_next u_next (
    .state_q      (state_q),
    .sio          (sio),
    .req          (req),
    .wake_clr     (wake_clr),
    .in_data_req  (in_data_req),
    .out_data_req (out_data_req),
    .state_d      (state_d),
    .code_d       (code_d),
    .vld_d        (vld_d)
  );

  // The code register loads only while a wakeup is raised or is being dropped.
  assign code_en = vld_d | wake_vld_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q    <= ST_IDLE;
      wake_vld_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      wake_vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  code_q <= WK_CTL;
    else if (code_en) code_q <= vld_d ? code_d : WK_CTL;
  end

  assign state     = state_q;
  assign wake_code = code_q;
  assign wake_vld  = wake_vld_q;

  // R3
  code_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wake_vld_q |-> code_q == WK_CTL);

  // R4
  idle_ctl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_IDLE && req.ctl) |=> (state_q == ST_CTL && wake_vld_q && code_q == WK_CTL));

  // R5
  idle_in_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_IDLE && req.in) |=> (state_q == ST_IN && wake_vld_q && code_q == WK_INSTART));

  // R8
  in_prio_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_IDLE && !sio && in_data_req) |=>
      (state_q == ST_IDLE && wake_vld_q && code_q == WK_INDATA));

  // R9
  out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    state_q == ST_OUT |-> !wake_vld_q);

  // R9
  out_exit_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_q == ST_OUT && !sio) |=> state_q == ST_IDLE);

  // R10
  held_wake_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_CTL || state_q == ST_IN) && (sio || !wake_clr)) |=>
      (wake_vld_q && $stable(state_q)));

  // R10
  release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((state_q == ST_CTL || state_q == ST_IN) && !sio && wake_clr) |=>
      (state_q == ST_IDLE && !wake_vld_q));
endmodule

// File: tb/test_hdq_dispatch.sv
`timescale 1ns/1ps
module test_hdq_dispatch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sio = 1'b0;
  logic [1:0] bus_cmd = 2'd0;
  logic       wake_clr = 1'b0;
  logic       in_data_req = 1'b0;
  logic       out_data_req = 1'b0;
  logic [1:0] state;
  logic [1:0] wake_code;
  logic       wake_vld;

  int n_checks = 0;
  int n_fail   = 0;

  int    m_state = 0;
  int    m_code  = 0;
  int    m_vld   = 0;
  string m_tag   = "R1";

  always #2 clk = ~clk;

  hdq_dispatch i_hdq_dispatch (
    .clk          (clk),
    .rst_n        (rst_n),
    .sio          (sio),
    .bus_cmd      (bus_cmd),
    .wake_clr     (wake_clr),
    .in_data_req  (in_data_req),
    .out_data_req (out_data_req),
    .state        (state),
    .wake_code    (wake_code),
    .wake_vld     (wake_vld)
  );

  // Behavioural reference: one step per clock edge.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_code = 0; m_vld = 0; m_tag = "R1";
    end else begin
      bit busy_reqs;
      busy_reqs = in_data_req || out_data_req || bus_cmd != 0;
      if (m_state == 0) begin
        m_vld = 0; m_code = 0;
        if (sio) begin
          if (bus_cmd == 3)      begin m_state = 2; m_vld = 1; m_code = 0; m_tag = "R4"; end
          else if (bus_cmd == 2) begin m_state = 3; m_vld = 1; m_code = 1; m_tag = "R5"; end
          else if (bus_cmd == 1) begin m_state = 1; m_tag = "R6"; end
          else m_tag = "R7";
        end else begin
          m_tag = "R8";
          if (in_data_req)       begin m_vld = 1; m_code = 2; end
          else if (out_data_req) begin m_vld = 1; m_code = 3; end
        end
      end else if (m_state == 1) begin
        m_vld = 0; m_code = 0;
        m_tag = busy_reqs ? "R9/R11" : "R9";
        if (!sio) m_state = 0;
      end else begin
        m_tag = busy_reqs ? "R10/R11" : "R10";
        if (!sio && wake_clr) begin
          m_state = 0; m_vld = 0; m_code = 0;
        end else begin
          m_vld = 1; m_code = (m_state == 2) ? 0 : 1;
        end
      end
    end
  end

  // Compares every output with the reference; R2 and R3 cover the encodings.
  task automatic check();
    n_checks++;
    if (state !== 2'(m_state) || wake_vld !== 1'(m_vld) || wake_code !== 2'(m_code)) begin
      n_fail++;
      $display("FAIL %s (R2/R3 encodings): state=%0d vld=%0d code=%0d expected state=%0d vld=%0d code=%0d",
               m_tag, state, wake_vld, wake_code, m_state, m_vld, m_code);
    end
  endtask

  task automatic cyc(input logic s, input logic [1:0] c, input logic k,
                     input logic ir, input logic orq);
    sio = s; bus_cmd = c; wake_clr = k; in_data_req = ir; out_data_req = orq;
    @(negedge clk);
    check();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check();                          // R1 while reset is held
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 0, 0);    // R1 release window, R8 quiet idle

    // R4 then R10: held with strobe despite ack, held without ack, released by ack
    cyc(1, 3, 0, 0, 0);
    cyc(1, 3, 1, 0, 0);
    cyc(1, 0, 1, 1, 1);               // R11 reqs ignored
    cyc(0, 0, 0, 1, 0);
    cyc(0, 2, 0, 0, 1);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);

    // R5 then R10 with R11 stimulus
    cyc(1, 2, 0, 1, 1);
    cyc(0, 1, 0, 1, 1);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);

    // R6 then R9
    cyc(1, 1, 0, 0, 0);
    cyc(1, 3, 1, 1, 1);
    cyc(1, 2, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);

    // R7: other device, data requests and ack ignored under the strobe
    cyc(1, 0, 1, 1, 1);
    cyc(1, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);

    // R8: input alone, output alone, both, none
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 0, 0, 0, 0);

    // R1: reset taken from set-control mid-run
    cyc(1, 3, 0, 0, 0);
    rst_n = 1'b0;
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) cyc(0, 0, 0, 0, 0);

    // Random stretch covering all requirements' transitions
    for (int i = 0; i < 2000; i++) begin
      cyc(($urandom % 3) == 0, 2'($urandom), ($urandom % 4) == 0,
          ($urandom % 3) == 0, ($urandom % 3) == 0);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #200us;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule